// File: doc/BRIEF.md
# FIFO Flag Offset Configuration Controller

This block sets up the four threshold offsets used by the almost-empty and almost-full flags of a pair of FIFOs. Both FIFOs leave reset together. On the first clock edge after reset is released, the block reads a three-pin strap code. The code selects one of three ways to obtain the offsets:

- **Preset.** A fixed value is written into all four offsets at once.
- **Serial.** The offsets are shifted in one bit at a time on a data/enable pin pair.
- **Parallel.** The offsets are captured from the low bits of the first four writes on the FIFO write bus.

Until the offsets are complete, the block keeps the write path closed. It drops input-ready and does not pass any write on to the FIFO memory. Once the offsets are complete, it raises a done flag and lets data writes through unchanged. The flag comparators and the memory arrays sit outside this block and take the four offset outputs.

Offsets are numbered in loading order:

| Slot | Offset |
|------|--------|
| 0 | FIFO1 almost-full |
| 1 | FIFO1 almost-empty |
| 2 | FIFO2 almost-full |
| 3 | FIFO2 almost-empty |

Every programmed value is forced into the legal window from 1 to DEPTH-4, which is 1 to 2044 with the default parameters.

Top module: `ofs_cfg_ctrl`

## Requirements
- R1: While rst_n is low, all four offsets read 0, and cfg_done, wr_ready and mem_wr_en are 0, even when wr_en is high.
- R2: The strap code {strap[2],strap[1],strap[0]} is sampled at the first clock edge after reset release. The preset codes are 111=64, 110=16, 101=8, 011=256 and 001=1024. A preset code loads its value into all four offsets and asserts cfg_done after that same edge.
- R3: Strap code 010 selects serial loading. Each edge with ser_en high shifts in ser_dat, most significant bit first. Every 11 bits complete one offset, in slot order 0,1,2,3. cfg_done rises after the 44th bit and is still low after the 43rd.
- R4: Strap code 100 selects parallel loading with a contiguous field. Each of the first four writes loads wr_data[10:0] into the next slot in order 0,1,2,3. wr_data[11] is ignored.
- R5: Strap code 000 selects parallel loading that skips the parity position. The offset is {wr_data[11:9], wr_data[7:0]}, and wr_data[8] is ignored.
- R6: Until cfg_done, wr_ready and mem_wr_en stay low. This includes a write presented in the same cycle as the final serial bit or the fourth parallel write. After cfg_done, mem_wr_en follows wr_en and cfg_done stays high.
- R7: A programmed value of 0 loads as 1. A value above 2044 loads as 2044.
- R8: After cfg_done, strap changes, ser_en activity and further writes leave all four offsets unchanged.
- R9: During serial loading, cycles with ser_en low shift nothing, whatever the level of ser_dat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| strap | input | 3 | Load-method select code, sampled after reset release |
| ser_en | input | 1 | Serial shift enable |
| ser_dat | input | 1 | Serial offset data, MSB first |
| wr_en | input | 1 | FIFO write request |
| wr_data | input | OFS_W+1 (12) | Low bits of the FIFO write data bus |
| wr_ready | output | 1 | Write path open (input ready) |
| mem_wr_en | output | 1 | Write forwarded to FIFO memory |
| cfg_done | output | 1 | All four offsets loaded |
| af1_off | output | OFS_W (11) | FIFO1 almost-full offset (slot 0) |
| ae1_off | output | OFS_W (11) | FIFO1 almost-empty offset (slot 1) |
| af2_off | output | OFS_W (11) | FIFO2 almost-full offset (slot 2) |
| ae2_off | output | OFS_W (11) | FIFO2 almost-empty offset (slot 3) |

## Verification
The finishing of configuration and a data write can fall in the same cycle. In serial mode this happens when wr_en is raised together with the 44th shifted bit. In parallel mode it happens when a write is the fourth one. The bench raises the write on exactly that cycle and judges two things at the ports: mem_wr_en must stay low for it, and the very next write must reach memory while the scoreboard confirms the loaded offsets.

// File: rtl/ofs_cfg_pkg.sv
package ofs_cfg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SERIAL,
        ST_PARALLEL,
        ST_DONE
    } cfg_state_e;

    typedef enum logic [1:0] {
        LM_PRESET,
        LM_SERIAL,
        LM_PAR_FLAT,
        LM_PAR_IP
    } load_mode_e;

    localparam int NUM_OFS = 4;

endpackage

// File: rtl/ofs_strap_decode.sv
module ofs_strap_decode
    import ofs_cfg_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [2:0]       strap,
    output load_mode_e       mode,
    output logic [OFS_W-1:0] preset
);

    always_comb begin
        mode   = LM_PRESET;
        preset = '0;
        unique case (strap)
            3'b111: preset = OFS_W'(64);
            3'b110: preset = OFS_W'(16);
            3'b101: preset = OFS_W'(8);
            3'b011: preset = OFS_W'(256);
            3'b001: preset = OFS_W'(1024);
            3'b010: mode   = LM_SERIAL;
            3'b100: mode   = LM_PAR_FLAT;
            default: mode  = LM_PAR_IP;
        endcase
    end

endmodule

// File: rtl/ofs_serial_shift.sv
module ofs_serial_shift #(
    parameter int OFS_W = 11,
    localparam int CNT_W = $clog2(OFS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ser_en,
    input  logic             ser_dat,
    output logic             word_vld,
    output logic [OFS_W-1:0] word
);

    typedef struct packed {
        logic [OFS_W-2:0] sh;
        logic [CNT_W-1:0] cnt;
    } shift_t;

    shift_t q, d;
    logic   take;

    assign take     = active && ser_en;
    assign word     = {q.sh, ser_dat};
    assign word_vld = take && (q.cnt == CNT_W'(OFS_W - 1));

    always_comb begin
        d = q;
        if (take) begin
            d.sh  = word[OFS_W-2:0];
            d.cnt = word_vld ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    ser_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> $stable(q.cnt));

endmodule

// File: rtl/ofs_par_extract.sv
module ofs_par_extract #(
    parameter int OFS_W    = 11,
    parameter int PAR_SKIP = 8
) (
    input  logic [OFS_W:0]   data,
    input  logic             ip,
    output logic [OFS_W-1:0] field
);

    assign field = ip ? {data[OFS_W:PAR_SKIP+1], data[PAR_SKIP-1:0]}
                      : data[OFS_W-1:0];

endmodule

// File: rtl/ofs_clamp.sv
module ofs_clamp #(
    parameter int OFS_W  = 11,
    parameter int LO_LIM = 1,
    parameter int HI_LIM = 2044
) (
    input  logic [OFS_W-1:0] raw,
    output logic [OFS_W-1:0] val
);

    always_comb begin
        if (raw < OFS_W'(LO_LIM))      val = OFS_W'(LO_LIM);
        else if (raw > OFS_W'(HI_LIM)) val = OFS_W'(HI_LIM);
        else                           val = raw;
    end

endmodule

// File: rtl/ofs_cfg_ctrl.sv
module ofs_cfg_ctrl
    import ofs_cfg_pkg::*;
#(
    parameter int DEPTH    = 2048,
    parameter int GUARD    = 4,
    parameter int PAR_SKIP = 8,
    localparam int OFS_W   = $clog2(DEPTH),
    localparam int OFS_MAX = DEPTH - GUARD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       strap,
    input  logic             ser_en,
    input  logic             ser_dat,
    input  logic             wr_en,
    input  logic [OFS_W:0]   wr_data,
    output logic             wr_ready,
    output logic             mem_wr_en,
    output logic             cfg_done,
    output logic [OFS_W-1:0] af1_off,
    output logic [OFS_W-1:0] ae1_off,
    output logic [OFS_W-1:0] af2_off,
    output logic [OFS_W-1:0] ae2_off
);

    typedef struct packed {
        cfg_state_e                    state;
        logic                          ip;
        logic [1:0]                    idx;
        logic [NUM_OFS-1:0][OFS_W-1:0] ofs;
    } ctrl_t;

    ctrl_t            q, d;
    load_mode_e       mode;
    logic [OFS_W-1:0] preset, par_field, ser_word, raw, clamped;
    logic             ser_vld;

    ofs_strap_decode #(.OFS_W(OFS_W)) i_decode (
        .strap (strap),
        .mode  (mode),
        .preset(preset)
    );

    ofs_serial_shift #(.OFS_W(OFS_W)) i_serial (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (q.state == ST_SERIAL),
        .ser_en  (ser_en),
        .ser_dat (ser_dat),
        .word_vld(ser_vld),
        .word    (ser_word)
    );

    ofs_par_extract #(.OFS_W(OFS_W), .PAR_SKIP(PAR_SKIP)) i_extract (
        .data (wr_data),
        .ip   (q.ip),
        .field(par_field)
    );

    assign raw = (q.state == ST_SERIAL) ? ser_word : par_field;

    ofs_clamp #(.OFS_W(OFS_W), .LO_LIM(1), .HI_LIM(OFS_MAX)) i_clamp (
        .raw(raw),
        .val(clamped)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_WAIT: begin
                d.idx = '0;
                unique case (mode)
                    LM_PRESET: begin
                        for (int i = 0; i < NUM_OFS; i++) d.ofs[i] = preset;
                        d.state = ST_DONE;
                    end
                    LM_SERIAL:   d.state = ST_SERIAL;
                    LM_PAR_FLAT: begin d.state = ST_PARALLEL; d.ip = 1'b0; end
                    default:     begin d.state = ST_PARALLEL; d.ip = 1'b1; end
                endcase
            end
            ST_SERIAL, ST_PARALLEL: begin
                if ((q.state == ST_SERIAL) ? ser_vld : wr_en) begin
                    d.ofs[q.idx] = clamped;
                    d.idx        = q.idx + 2'd1;
                    if (q.idx == 2'(NUM_OFS - 1)) d.state = ST_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_WAIT, default: '0};
        else        q <= d;
    end

    assign cfg_done  = (q.state == ST_DONE);
    assign wr_ready  = cfg_done;
    assign mem_wr_en = wr_en && cfg_done;
    assign af1_off   = q.ofs[0];
    assign ae1_off   = q.ofs[1];
    assign af2_off   = q.ofs[2];
    assign ae2_off   = q.ofs[3];

    // R4
    par_load_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PARALLEL && wr_en) |=> (q.idx == $past(q.idx) + 2'd1));

    // R7
    ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (af1_off >= 1 && af1_off <= OFS_MAX && ae1_off >= 1 && ae1_off <= OFS_MAX
                   && af2_off >= 1 && af2_off <= OFS_MAX && ae2_off >= 1 && ae2_off <= OFS_MAX));

    // R8
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> $stable(q.ofs));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

endmodule

// File: tb/test_ofs_cfg_ctrl.sv
`timescale 1ns/1ps
module test_ofs_cfg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap = 3'b111;
    logic        ser_en = 1'b0, ser_dat = 1'b0, wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic        wr_ready, mem_wr_en, cfg_done;
    logic [10:0] af1_off, ae1_off, af2_off, ae2_off;

    typedef struct {
        int    v[4];
        string tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_exp;
    int   checks = 0, fails = 0;
    bit   finished = 1'b0;
    logic done_prev = 1'b0;

    always #2.5 clk = ~clk;

    ofs_cfg_ctrl i_ofs_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .strap(strap), .ser_en(ser_en), .ser_dat(ser_dat),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .mem_wr_en(mem_wr_en),
        .cfg_done(cfg_done), .af1_off(af1_off), .ae1_off(ae1_off),
        .af2_off(af2_off), .ae2_off(ae2_off)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clampv(int v);
        return (v < 1) ? 1 : (v > 2044) ? 2044 : v;
    endfunction

    task automatic chk_ofs(string req, exp_t e);
        chk(req, {e.tag, " af1"}, int'(af1_off), e.v[0]);
        chk(req, {e.tag, " ae1"}, int'(ae1_off), e.v[1]);
        chk(req, {e.tag, " af2"}, int'(af2_off), e.v[2]);
        chk(req, {e.tag, " ae2"}, int'(ae2_off), e.v[3]);
    endtask

    // Monitor: pops the scoreboard when configuration completes
    always @(negedge clk) begin
        if (cfg_done && !done_prev) begin
            if (sb_q.size() == 0) chk("R2", "unexpected done", 1, 0);
            else begin
                last_exp = sb_q.pop_front();
                chk_ofs(last_exp.tag.substr(0, 1), last_exp);
            end
        end
        done_prev = cfg_done;
    end

    task automatic start(logic [2:0] code, exp_t e);
        @(negedge clk);
        rst_n = 1'b0; strap = code; ser_en = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        sb_q.push_back(e);
        rst_n = 1'b1;
    endtask

    task automatic ser_word(int v, bit last);
        for (int i = 10; i >= 0; i--) begin
            if (i == 5) begin
                @(negedge clk); ser_en = 1'b0; ser_dat = ~v[i];   // R9 idle cycle
            end
            @(negedge clk);
            ser_en = 1'b1; ser_dat = v[i];
            if (last && i == 0) begin
                chk("R3", "done before 44th bit", int'(cfg_done), 0);
                wr_en = 1'b1; #1;
                chk("R6", "same-cycle write on final bit", int'(mem_wr_en), 0);
            end
        end
        @(negedge clk); ser_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic par_write(logic [11:0] dat, bit expect_mem);
        @(negedge clk);
        wr_en = 1'b1; wr_data = dat; #1;
        chk("R6", "mem_wr_en", int'(mem_wr_en), int'(expect_mem));
        if (!expect_mem) chk("R6", "wr_ready", int'(wr_ready), 0);
    endtask

    initial begin
        exp_t e;
        int   sv[4];
        int   pv[4];
        // R1 reset state
        wr_en = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset af1", int'(af1_off), 0);
        chk("R1", "reset ae2", int'(ae2_off), 0);
        chk("R1", "reset done", int'(cfg_done), 0);
        chk("R1", "reset ready", int'(wr_ready), 0);
        chk("R1", "reset mem_wr_en", int'(mem_wr_en), 0);
        wr_en = 1'b0;

        // R2 presets
        begin
            logic [2:0] codes[5] = '{3'b111, 3'b110, 3'b101, 3'b011, 3'b001};
            int         vals[5]  = '{64, 16, 8, 256, 1024};
            for (int k = 0; k < 5; k++) begin
                e.v = '{vals[k], vals[k], vals[k], vals[k]}; e.tag = "R2 preset";
                start(codes[k], e);
                @(negedge clk); #1;
                chk("R2", "done one edge after release", int'(cfg_done), 1);
                repeat (2) @(negedge clk);
            end
        end
        // R8 ignore activity after done (preset 1024 loaded)
        @(negedge clk);
        strap = 3'b000; ser_en = 1'b1; ser_dat = 1'b1; wr_en = 1'b1; wr_data = 12'h005; #1;
        chk("R6", "write passes after done", int'(mem_wr_en), 1);
        repeat (12) @(negedge clk);
        ser_en = 0; wr_en = 0; #1;
        e.v = '{1024, 1024, 1024, 1024}; e.tag = "R8 hold";
        chk_ofs("R8", e);

        // R3 serial with R7 clamps and R9 idle cycles
        sv = '{1234, 0, 2047, 5};
        e.v = '{1234, clampv(0), clampv(2047), 5}; e.tag = "R3 serial";
        start(3'b010, e);
        for (int w = 0; w < 4; w++) ser_word(sv[w], w == 3);
        #1;
        chk("R6", "ready after serial", int'(wr_ready), 1);
        @(negedge clk); wr_en = 1'b1; #1;
        chk("R6", "write after serial done", int'(mem_wr_en), 1);
        @(negedge clk); wr_en = 1'b0;

        // R4 parallel contiguous, bit 11 junk; R7 clamps
        pv = '{300, 0, 2045, 2044};
        e.v = '{300, 1, 2044, 2044}; e.tag = "R4 flat";
        start(3'b100, e);
        @(negedge clk);
        for (int w = 0; w < 4; w++) par_write({1'b1, 11'(pv[w])}, 1'b0);
        par_write(12'h0AA, 1'b1);
        @(negedge clk); wr_en = 1'b0; #1;
        chk_ofs("R8", e);

        // R5 parallel interspersed, bit 8 junk
        pv = '{1000, 7, 1500, 2};
        e.v = '{1000, 7, 1500, 2}; e.tag = "R5 ip";
        start(3'b000, e);
        @(negedge clk);
        for (int w = 0; w < 4; w++)
            par_write({pv[w][10:8], ~pv[w][0], pv[w][7:0]}, 1'b0);
        par_write(12'hFFF, 1'b1);
        @(negedge clk); wr_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "scoreboard drained", sb_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule